// File: doc/BRIEF.md
# Multi-Port Request Dealer

The dealer splits one incoming stream of memory requests (load or store, address, write data) across NPORT per-processor request ports. It also folds the responses coming back from those ports into a single output stream, and each response carries the index of the port that produced it. It sits at the front of a multiprocessor test harness. Serialized dispatch lets each processor path be exercised alone. Streaming dispatch then loads all paths at once.

The target port advances round-robin through 0..NPORT-1 and wraps after each accepted request. The request fields are broadcast on a shared bus, and a one-hot valid vector selects the target.

Dispatch has two modes:
- **Serialized:** a request is issued only when nothing is outstanding, so the dealer waits for each response before it serves the next port.
- **Streaming:** requests leave as fast as the target port accepts them, up to MAXOUT outstanding.

Back-pressure follows valid/ready. The input stream is accepted when `in_valid && in_ready`. A target port that is not ready stalls the input: the dealer does not skip to another port, so stream order is preserved. A per-port response is consumed when `rsp_valid_i[p] && rsp_ready_o[p]`. The merged output is consumed when `out_rsp_valid && out_rsp_ready`. While `out_rsp_ready` is low, no port response is taken.

Top module: `req_dealer`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `outstanding` is 0, `prt_valid` is all zero and `out_rsp_valid` is 0.
- R2: At most one bit of `prt_valid` is set, and it is the bit of the current target port. `prt_store`, `prt_addr` and `prt_wdata` equal the input fields. The target starts at port 0 after reset and advances by one, wrapping from NPORT-1 to 0, on every accepted request.
- R3: In streaming mode (`serial_mode` = 0), `in_ready` equals the target port's ready whenever fewer than MAXOUT requests are outstanding. Accepted requests need no response before the next one is dispatched.
- R4: When the target port is not ready, `in_ready` is 0 and the request stays presented on that same port until it is accepted. No other port receives it.
- R5: In serialized mode (`serial_mode` = 1), no port valid is raised and `in_ready` is 0 while `outstanding` is nonzero.
- R6: The `serial_mode` input is adopted only on a clock edge at which `outstanding` is 0. A change made while requests are outstanding has no effect on dispatch until the count returns to 0.
- R7: `out_rsp_valid` is high when any `rsp_valid_i` bit is set. `out_rsp_port` names the granted port and `out_rsp_data` carries that port's `rsp_data_i` slice (bits p*DW..p*DW+DW-1). The grant is round-robin: the search starts at the port after the last granted one, starting from port 0 after reset.
- R8: `rsp_ready_o` has at most one bit set, and only for the granted port while `out_rsp_ready` is 1. While `out_rsp_ready` is 0, no response is consumed.
- R9: `outstanding` rises by one on each accepted request and falls by one on each consumed merged response. It is unchanged when both occur in the same cycle.
- R10: In streaming mode `in_ready` is 0 while `outstanding` equals MAXOUT, and `outstanding` never exceeds MAXOUT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| serial_mode | input | 1 | 1 = serialized dispatch, 0 = streaming |
| in_valid | input | 1 | Input request valid |
| in_ready | output | 1 | Input request accepted this cycle when valid |
| in_store | input | 1 | 1 = store, 0 = load |
| in_addr | input | AW | Request address |
| in_wdata | input | DW | Store data |
| prt_valid | output | NPORT | One-hot request valid per port |
| prt_ready | input | NPORT | Per-port request ready |
| prt_store | output | 1 | Broadcast store flag |
| prt_addr | output | AW | Broadcast address |
| prt_wdata | output | DW | Broadcast store data |
| rsp_valid_i | input | NPORT | Per-port response valid |
| rsp_ready_o | output | NPORT | Per-port response ready |
| rsp_data_i | input | NPORT*DW | Packed per-port response data |
| out_rsp_valid | output | 1 | Merged response valid |
| out_rsp_ready | input | 1 | Merged response ready |
| out_rsp_data | output | DW | Merged response data |
| out_rsp_port | output | PW | Source port of merged response |
| outstanding | output | CW | Count of requests awaiting response |

## Verification
The bench builds the dealer with NPORT = 4, MAXOUT = 6 and 8-bit address and data.

With four ports, nine serialized requests wrap the target pointer twice. A six-deep window fills in a handful of cycles, so the cap, the stall-without-skip case and a mode change made under load are all reached.

Four ports also give the bench responses from every port at once and a sparse response mask. With these it predicts each round-robin grant arithmetically from the previously granted port, including a back-pressured output and a response that coincides with a dispatch.

// File: rtl/dealer_pkg.sv
package dealer_pkg;
  typedef enum logic {
    MODE_STREAM = 1'b0,
    MODE_SERIAL = 1'b1
  } dealer_mode_e;
endpackage

// File: rtl/dealer_dispatch.sv
// Round-robin target pointer and per-port request valid generation.
module dealer_dispatch #(
  parameter int NPORT = 4,
  parameter int PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             allow,
  input  logic [NPORT-1:0] port_ready,
  output logic [NPORT-1:0] port_valid,
  output logic             in_ready,
  output logic             fire
);
  localparam logic [PW-1:0] LAST = PW'(NPORT - 1);

  logic [PW-1:0] tgt_q;

  assign in_ready = allow && port_ready[tgt_q];
  assign fire     = in_valid && in_ready;

  for (genvar g = 0; g < NPORT; g++) begin : g_pv
    assign port_valid[g] = in_valid && allow && (tgt_q == PW'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_q <= '0;
    end else if (fire) begin
      tgt_q <= (tgt_q == LAST) ? '0 : tgt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dealer_occupancy.sv
// Outstanding-request counter and mode latch gated on an empty window.
module dealer_occupancy
  import dealer_pkg::*;
#(
  parameter int MAXOUT = 6,
  parameter int CW     = $clog2(MAXOUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_req,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] count,
  output logic          mode_serial,
  output logic          allow
);
  dealer_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      mode_q <= MODE_STREAM;
    end else begin
      if (count == '0) mode_q <= dealer_mode_e'(mode_req);
      case ({inc, dec})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign mode_serial = (mode_q == MODE_SERIAL);
  assign allow = mode_serial ? (count == '0) : (count < CW'(MAXOUT));
endmodule

// File: rtl/dealer_rsp_arb.sv
// Round-robin merge of per-port responses into one tagged stream.
module dealer_rsp_arb #(
  parameter int NPORT = 4,
  parameter int DW    = 8,
  parameter int PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPORT-1:0]    rsp_valid,
  input  logic [NPORT*DW-1:0] rsp_data,
  output logic [NPORT-1:0]    rsp_ready,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DW-1:0]       out_data,
  output logic [PW-1:0]       out_port,
  output logic                fire
);
  localparam logic [PW-1:0] LAST = PW'(NPORT - 1);

  logic [PW-1:0] rr_q;
  logic [PW-1:0] pick;
  logic [PW-1:0] idx;
  logic          found;

  always_comb begin
    pick  = rr_q;
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < NPORT; k++) begin
      idx = PW'((int'(rr_q) + k) % NPORT);
      if (!found && rsp_valid[idx]) begin
        found = 1'b1;
        pick  = idx;
      end
    end
  end

  assign out_valid = found;
  assign out_port  = pick;
  assign out_data  = rsp_data[int'(pick)*DW +: DW];
  assign fire      = found && out_ready;

  for (genvar g = 0; g < NPORT; g++) begin : g_rr
    assign rsp_ready[g] = fire && (pick == PW'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (fire) begin
      rr_q <= (pick == LAST) ? '0 : pick + 1'b1;
    end
  end
endmodule

// File: rtl/req_dealer.sv
module req_dealer #(
  parameter int NPORT  = 4,
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int MAXOUT = 6,
  parameter int PW     = (NPORT > 1) ? $clog2(NPORT) : 1,
  parameter int CW     = $clog2(MAXOUT + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                serial_mode,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_store,
  input  logic [AW-1:0]       in_addr,
  input  logic [DW-1:0]       in_wdata,
  output logic [NPORT-1:0]    prt_valid,
  input  logic [NPORT-1:0]    prt_ready,
  output logic                prt_store,
  output logic [AW-1:0]       prt_addr,
  output logic [DW-1:0]       prt_wdata,
  input  logic [NPORT-1:0]    rsp_valid_i,
  output logic [NPORT-1:0]    rsp_ready_o,
  input  logic [NPORT*DW-1:0] rsp_data_i,
  output logic                out_rsp_valid,
  input  logic                out_rsp_ready,
  output logic [DW-1:0]       out_rsp_data,
  output logic [PW-1:0]       out_rsp_port,
  output logic [CW-1:0]       outstanding
);
  logic allow;
  logic eff_serial;
  logic req_fire;
  logic rsp_fire;

  assign prt_store = in_store;
  assign prt_addr  = in_addr;
  assign prt_wdata = in_wdata;

  dealer_occupancy #(.MAXOUT(MAXOUT), .CW(CW)) occ_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_req   (serial_mode),
    .inc        (req_fire),
    .dec        (rsp_fire),
    .count      (outstanding),
    .mode_serial(eff_serial),
    .allow      (allow)
  );

  dealer_dispatch #(.NPORT(NPORT), .PW(PW)) disp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .allow     (allow),
    .port_ready(prt_ready),
    .port_valid(prt_valid),
    .in_ready  (in_ready),
    .fire      (req_fire)
  );

  dealer_rsp_arb #(.NPORT(NPORT), .DW(DW), .PW(PW)) arb_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rsp_valid(rsp_valid_i),
    .rsp_data (rsp_data_i),
    .rsp_ready(rsp_ready_o),
    .out_valid(out_rsp_valid),
    .out_ready(out_rsp_ready),
    .out_data (out_rsp_data),
    .out_port (out_rsp_port),
    .fire     (rsp_fire)
  );
endmodule

// File: rtl/dealer_checker.sv
module dealer_checker #(
  parameter int NPORT  = 4,
  parameter int MAXOUT = 6,
  parameter int PW     = 2,
  parameter int CW     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [NPORT-1:0] prt_valid,
  input logic [NPORT-1:0] rsp_valid_i,
  input logic [NPORT-1:0] rsp_ready_o,
  input logic             out_rsp_valid,
  input logic             out_rsp_ready,
  input logic [PW-1:0]    out_rsp_port,
  input logic [CW-1:0]    outstanding,
  input logic             eff_serial
);
  AST_PORT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(prt_valid)); // R2
  AST_SERIAL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_serial && outstanding != '0) |-> (prt_valid == '0 && !in_ready)); // R5
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (outstanding != '0) |=> $stable(eff_serial)); // R6
  AST_TAG_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    out_rsp_valid |-> rsp_valid_i[out_rsp_port]); // R7
  AST_RSP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_ready_o) && (out_rsp_ready || rsp_ready_o == '0)); // R8
  AST_CNT_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !(out_rsp_valid && out_rsp_ready))
      |=> outstanding == CW'($past(outstanding) + 1'b1)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding <= CW'(MAXOUT)); // R10
endmodule

bind req_dealer dealer_checker #(
  .NPORT(NPORT), .MAXOUT(MAXOUT), .PW(PW), .CW(CW)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .prt_valid    (prt_valid),
  .rsp_valid_i  (rsp_valid_i),
  .rsp_ready_o  (rsp_ready_o),
  .out_rsp_valid(out_rsp_valid),
  .out_rsp_ready(out_rsp_ready),
  .out_rsp_port (out_rsp_port),
  .outstanding  (outstanding),
  .eff_serial   (eff_serial)
);

// File: tb/req_dealer_tb_top.sv
`timescale 1ns/1ps
module req_dealer_tb_top;
  localparam int N = 4, AW = 8, DW = 8, MO = 6;

  logic clk = 0, rst_n = 0, serial_mode = 1;
  logic in_valid = 0, in_store = 0;
  logic [AW-1:0] in_addr = 0;
  logic [DW-1:0] in_wdata = 0;
  logic [N-1:0] prt_ready = '1, rsp_valid_i = '0;
  logic [N*DW-1:0] rsp_data_i = '0;
  logic out_rsp_ready = 1;
  wire in_ready, prt_store, out_rsp_valid;
  wire [N-1:0] prt_valid, rsp_ready_o;
  wire [AW-1:0] prt_addr;
  wire [DW-1:0] prt_wdata, out_rsp_data;
  wire [1:0] out_rsp_port;
  wire [2:0] outstanding;

  int errors = 0, checks = 0, exp_tgt = 0, exp_rr = 0, exp_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  req_dealer #(.NPORT(N), .AW(AW), .DW(DW), .MAXOUT(MO)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  task automatic cnt_chk(input string req);
    chk(outstanding == exp_cnt, req, outstanding, exp_cnt);
  endtask

  // called just after a negedge
  task automatic send(input bit st, input int a, input int d);
    in_valid = 1; in_store = st; in_addr = AW'(a); in_wdata = DW'(d);
    #1;
    chk(in_ready == 1, "R3 in_ready", in_ready, 1);
    chk(prt_valid == N'(1 << exp_tgt), "R2 target", prt_valid, 1 << exp_tgt);
    chk(prt_addr == AW'(a) && prt_wdata == DW'(d) && prt_store == st, "R2 fields", prt_addr, a);
    @(posedge clk); @(negedge clk);
    in_valid = 0;
    exp_tgt = (exp_tgt + 1) % N;
    exp_cnt++;
    #1 cnt_chk("R9 inc");
  endtask

  task automatic grant_burst(input logic [N-1:0] mask, input int base);
    logic [N-1:0] pend = mask;
    for (int p = 0; p < N; p++) rsp_data_i[p*DW +: DW] = DW'(base + p);
    rsp_valid_i = mask;
    while (pend != 0) begin
      int e = -1;
      for (int k = 0; k < N; k++)
        if (e < 0 && pend[(exp_rr + k) % N]) e = (exp_rr + k) % N;
      #1;
      chk(out_rsp_valid == 1, "R7 valid", out_rsp_valid, 1);
      chk(out_rsp_port == 2'(e), "R7 rr tag", out_rsp_port, e);
      chk(out_rsp_data == DW'(base + e), "R7 data", out_rsp_data, base + e);
      chk(rsp_ready_o == N'(1 << e), "R8 ready", rsp_ready_o, 1 << e);
      @(posedge clk); @(negedge clk);
      pend[e] = 0; rsp_valid_i = pend;
      exp_rr = (e + 1) % N;
      exp_cnt--;
      #1 cnt_chk("R9 dec");
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(outstanding == 0, "R1 count", outstanding, 0);
    chk(prt_valid == 0, "R1 prt_valid", prt_valid, 0);
    chk(out_rsp_valid == 0, "R1 out_valid", out_rsp_valid, 0);
    @(negedge clk); rst_n = 1;
    #1 chk(outstanding == 0 && prt_valid == 0, "R1 after release", outstanding, 0);
    @(posedge clk); @(negedge clk); // serial mode adopted

    // serialized sweep, wraps target twice
    for (int i = 0; i < 9; i++) begin
      int p = exp_tgt;
      send(i[0], 16 + i, 100 + i);
      in_valid = 1;
      repeat (2) begin
        #1;
        chk(in_ready == 0 && prt_valid == 0, "R5 blocked", prt_valid, 0);
        @(negedge clk);
      end
      grant_burst(N'(1 << p), 8'h40 + i);
      in_valid = 0;
    end

    // streaming: fill to the cap
    serial_mode = 0;
    @(negedge clk);
    for (int i = 0; i < MO; i++) send(0, 32 + i, 200 + i);
    in_valid = 1; #1;
    chk(in_ready == 0 && prt_valid == 0, "R10 cap", in_ready, 0);
    @(negedge clk); in_valid = 0;

    // mode change under load is ignored
    serial_mode = 1;
    repeat (2) @(negedge clk);
    grant_burst(4'b0010, 8'h60);
    send(1, 48, 77);
    chk(exp_cnt == MO, "R6 streaming kept", exp_cnt, MO);
    serial_mode = 0;

    // merged output back-pressure then full burst
    out_rsp_ready = 0;
    rsp_valid_i = 4'b1111;
    repeat (2) begin
      #1;
      chk(out_rsp_valid == 1 && rsp_ready_o == 0, "R8 hold", rsp_ready_o, 0);
      @(negedge clk);
      #1 cnt_chk("R8 no consume");
    end
    out_rsp_ready = 1;
    grant_burst(4'b1111, 8'h80);
    grant_burst(4'b1001, 8'h90);
    chk(outstanding == 0, "R9 empty", outstanding, 0);

    // stall without skipping
    prt_ready = '1; prt_ready[exp_tgt] = 0;
    in_valid = 1;
    repeat (3) begin
      #1;
      chk(in_ready == 0 && prt_valid == N'(1 << exp_tgt), "R4 stall", prt_valid, 1 << exp_tgt);
      @(negedge clk);
    end
    prt_ready = '1;
    send(0, 99, 55);

    // dispatch and response in the same cycle
    begin
      int p = (exp_tgt + N - 1) % N;
      rsp_data_i[p*DW +: DW] = 8'hEE;
      rsp_valid_i = N'(1 << p);
      in_valid = 1; in_addr = 8'h77;
      #1;
      chk(in_ready == 1 && out_rsp_port == 2'(p), "R9 both", out_rsp_port, p);
      @(posedge clk); @(negedge clk);
      rsp_valid_i = 0; in_valid = 0;
      exp_rr = (p + 1) % N;
      exp_tgt = (exp_tgt + 1) % N;
      #1 cnt_chk("R9 both unchanged");
    end
    grant_burst(N'(1 << ((exp_tgt + N - 1) % N)), 8'hC0);
    chk(outstanding == 0, "R9 final", outstanding, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule